// File: doc/BRIEF.md
# Register Access Packet Engine

This block takes host command packets that have already been unframed and executes them against an internal 8-bit register bus. Incoming bytes arrive one per cycle with start and end markers. The first four bytes of a packet form a header: command, peripheral byte, register address and request count. The command picks the direction. It also picks whether the register address advances after each access or stays on one register, which suits queue-backed registers.

When the packet ends, the engine raises a request to a response arbiter and waits for the grant. Once granted, it sends back the four header bytes. For a read it then performs the register reads and forwards each returned byte. The response ends with a byte that gives how many of the requested bytes were not moved. A peripheral that drops its accept signal ends the transfer early, and the shortfall appears in that final byte. Write data is applied to the bus as it arrives, so a write response holds only the echoed header and the final count.

The control is one state machine with these states:

- IDLE waits for a start marker.
- HDR collects the header.
- WDATA performs writes.
- RWAIT waits for the end of a read packet.
- DROP skips the rest of a rejected packet.
- REQ waits for the grant.
- SHDR echoes the header.
- RXFER performs reads.
- TAIL sends the final count.

The transitions are as follows:

- IDLE→HDR on a start byte.
- HDR→WDATA, RWAIT or REQ after the fourth header byte of a good header.
- HDR→DROP after the fourth byte of a bad header.
- HDR→IDLE when the packet ends before the header is complete.
- WDATA→REQ and RWAIT→REQ on the end marker.
- DROP→IDLE on the end marker.
- Any receiving state→HDR on a fresh start byte.
- REQ→SHDR on grant.
- SHDR→RXFER for reads, or SHDR→TAIL for writes.
- RXFER→TAIL when the count is used up or accept is low.
- TAIL→IDLE.

Top module: `rae_top`

## Requirements
- R1: Every response starts with the four header bytes in arrival order and ends with the not-transferred count byte. `out_sop` is set only on the first output byte and `out_eop` only on the last.
- R2: Command 0xF6 reads consecutive registers starting at the header address. Command 0xF4 reads the header address repeatedly. Bit 1 of the command selects address increment and bit 3 selects write.
- R3: Command 0xFA writes the data bytes that follow the header to consecutive registers. Command 0xF8 writes them all to one register. A write response has exactly five bytes: the header and the count.
- R4: The peripheral byte must have bits 7:5 all ones. `bus_sel` carries its bits 4:0 during every access.
- R5: A packet is discarded without a response and without any bus access in three cases: its command is not one of 0xF4, 0xF6, 0xF8 or 0xFA; its peripheral byte lacks the 111 prefix; or it ends before four bytes.
- R6: During auto-increment the register address wraps from 0xFF to 0x00.
- R7: A read cycle with `bus_ack` low ends the read and produces no data byte. The final byte equals the request count minus the reads that were accepted.
- R8: A write cycle with `bus_ack` low ends the write, and every later data byte of that packet is dropped. The final byte equals the request count minus the writes that were accepted.
- R9: A write packet that carries fewer data bytes than its count reports the missing ones in the final byte. Data bytes beyond the count are never written.
- R10: A request count of 0 causes no bus access and returns a count byte of 0. A count of 255 moves 255 bytes.
- R11: `rsp_req` rises after the packet's end marker and stays high until the final byte is sent. No output byte and no read access occurs before `rsp_gnt` is seen. After reset, all outputs are low.
- R12: Bytes that arrive while a response is pending or being sent are ignored. A start marker inside an unfinished packet abandons that packet and begins a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| rsp_req | output | 1 | Request for the response path |
| rsp_gnt | input | 1 | Grant of the response path, held while requested |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a response |
| out_eop | output | 1 | Last byte of a response |
| bus_sel | output | 5 | Peripheral number |
| bus_addr | output | 8 | Register address |
| bus_rd | output | 1 | Read strobe, one cycle per access |
| bus_wr | output | 1 | Write strobe, one cycle per access |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the strobe cycle |
| bus_ack | input | 1 | Access accepted in the strobe cycle |

## Verification
The bench uses a register model filled with a pattern that differs at every address. This lets fixed-address and incrementing reads tell apart a repeated register from a stepping one, and shows whether a wrap went to 0x00. Count patterns of 0, 1 to 5 and 255 separate the empty transfer, ordinary transfers and the maximum one. Accept limits of one and two accesses, together with short and over-long write packets, show whether the final count tracks the accepted bytes rather than the bytes offered. Malformed headers, a withheld grant, packets sent while a response is pending, and a restart in mid-packet show that nothing leaks onto the bus or the output.

// File: rtl/rae_pkg.sv
package rae_pkg;

    localparam int RAE_BYTE_W  = 8;
    localparam int RAE_HDR_LEN = 4;

    localparam logic [7:0] CMD_RD_FIX = 8'hF4;
    localparam logic [7:0] CMD_RD_INC = 8'hF6;
    localparam logic [7:0] CMD_WR_FIX = 8'hF8;
    localparam logic [7:0] CMD_WR_INC = 8'hFA;

    localparam int CMD_BIT_INC = 1;
    localparam int CMD_BIT_WR  = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDATA,
        ST_RWAIT,
        ST_DROP,
        ST_REQ,
        ST_SHDR,
        ST_RXFER,
        ST_TAIL
    } rae_state_e;

endpackage

// File: rtl/rae_hdr.sv
module rae_hdr
    import rae_pkg::*;
#(
    parameter int SEL_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cap,
    input  logic [$clog2(RAE_HDR_LEN)-1:0] cap_idx,
    input  logic [RAE_BYTE_W-1:0]         din,
    input  logic [$clog2(RAE_HDR_LEN)-1:0] rd_idx,
    output logic [RAE_BYTE_W-1:0]         echo_byte,
    output logic [SEL_W-1:0]              sel,
    output logic [RAE_BYTE_W-1:0]         reg_addr,
    output logic                          is_wr,
    output logic                          is_inc,
    output logic                          hdr_ok
);
    localparam int TAG_W = RAE_BYTE_W - SEL_W;

    logic [RAE_HDR_LEN-1:0][RAE_BYTE_W-1:0] hb;
    logic                                   cmd_known;
    logic                                   tag_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hb <= '0;
        end else if (cap) begin
            for (int i = 0; i < RAE_HDR_LEN; i++) begin
                if (cap_idx == i[$clog2(RAE_HDR_LEN)-1:0]) begin
                    hb[i] <= din;
                end
            end
        end
    end

    always_comb begin
        cmd_known = (hb[0] == CMD_RD_FIX) || (hb[0] == CMD_RD_INC) ||
                    (hb[0] == CMD_WR_FIX) || (hb[0] == CMD_WR_INC);
        tag_ok    = (hb[1][RAE_BYTE_W-1:SEL_W] == {TAG_W{1'b1}});
        hdr_ok    = cmd_known && tag_ok;
        is_wr     = hb[0][CMD_BIT_WR];
        is_inc    = hb[0][CMD_BIT_INC];
        sel       = hb[1][SEL_W-1:0];
        reg_addr  = hb[2];
        echo_byte = hb[rd_idx];
    end

endmodule

// File: rtl/rae_xfer.sv
module rae_xfer #(
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_cnt,
    input  logic          inc,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] left,
    output logic          empty
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            left <= '0;
        end else if (load) begin
            addr <= load_addr;
            left <= load_cnt;
        end else if (step) begin
            if (inc) begin
                addr <= addr + AW'(1);
            end
            left <= left - CW'(1);
        end
    end

    assign empty = (left == '0);

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !inc) |=> (addr == $past(addr)));                       // R2
    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && inc && (addr == {AW{1'b1}})) |=> (addr == '0));        // R6
    AST_LEFT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (left == $past(left) - CW'(1)));                       // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (left != '0));                                         // R10

endmodule

// File: rtl/rae_fmt.sv
module rae_fmt #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          emit_valid,
    input  logic [DW-1:0] emit_data,
    input  logic          emit_sop,
    input  logic          emit_eop,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_sop,
    output logic          out_eop
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else begin
            out_valid <= emit_valid;
            out_data  <= emit_valid ? emit_data : '0;
            out_sop   <= emit_valid && emit_sop;
            out_eop   <= emit_valid && emit_eop;
        end
    end

    AST_MARK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);                            // R1
    AST_GAP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eop) |=> !out_valid);                         // R1

endmodule

// File: rtl/rae_top.sv
module rae_top
    import rae_pkg::*;
#(
    parameter int SEL_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [RAE_BYTE_W-1:0] in_data,
    input  logic                  in_sop,
    input  logic                  in_eop,
    output logic                  rsp_req,
    input  logic                  rsp_gnt,
    output logic                  out_valid,
    output logic [RAE_BYTE_W-1:0] out_data,
    output logic                  out_sop,
    output logic                  out_eop,
    output logic [SEL_W-1:0]      bus_sel,
    output logic [RAE_BYTE_W-1:0] bus_addr,
    output logic                  bus_rd,
    output logic                  bus_wr,
    output logic [RAE_BYTE_W-1:0] bus_wdata,
    input  logic [RAE_BYTE_W-1:0] bus_rdata,
    input  logic                  bus_ack
);
    localparam int IDX_W = $clog2(RAE_HDR_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(RAE_HDR_LEN - 1);

    rae_state_e state, nstate;

    logic [IDX_W-1:0]      hidx, hidx_n;
    logic                  stopped;
    logic                  stop_set, stop_clr;
    logic                  cap;
    logic [IDX_W-1:0]      cap_idx;
    logic                  load, step;
    logic                  restart;
    logic                  emit_valid, emit_sop, emit_eop;
    logic [RAE_BYTE_W-1:0] emit_data;

    logic [RAE_BYTE_W-1:0] echo_byte, reg_addr, left;
    logic                  is_wr, is_inc, hdr_ok, empty;

    rae_hdr #(.SEL_W(SEL_W)) u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .cap_idx   (cap_idx),
        .din       (in_data),
        .rd_idx    (hidx),
        .echo_byte (echo_byte),
        .sel       (bus_sel),
        .reg_addr  (reg_addr),
        .is_wr     (is_wr),
        .is_inc    (is_inc),
        .hdr_ok    (hdr_ok)
    );

    rae_xfer #(.AW(RAE_BYTE_W), .CW(RAE_BYTE_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (reg_addr),
        .load_cnt  (in_data),
        .inc       (is_inc),
        .step      (step),
        .addr      (bus_addr),
        .left      (left),
        .empty     (empty)
    );

    rae_fmt #(.DW(RAE_BYTE_W)) u_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit_valid (emit_valid),
        .emit_data  (emit_data),
        .emit_sop   (emit_sop),
        .emit_eop   (emit_eop),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_sop    (out_sop),
        .out_eop    (out_eop)
    );

    // State register and small control flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            hidx    <= '0;
            stopped <= 1'b0;
        end else begin
            state <= nstate;
            hidx  <= hidx_n;
            if (stop_clr) begin
                stopped <= 1'b0;
            end else if (stop_set) begin
                stopped <= 1'b1;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        nstate     = state;
        hidx_n     = hidx;
        cap        = 1'b0;
        cap_idx    = hidx;
        load       = 1'b0;
        step       = 1'b0;
        stop_set   = 1'b0;
        stop_clr   = 1'b0;
        bus_rd     = 1'b0;
        bus_wr     = 1'b0;
        bus_wdata  = in_data;
        emit_valid = 1'b0;
        emit_data  = '0;
        emit_sop   = 1'b0;
        emit_eop   = 1'b0;
        rsp_req    = 1'b0;

        restart = in_valid && in_sop &&
                  ((state == ST_IDLE) || (state == ST_HDR) || (state == ST_WDATA) ||
                   (state == ST_RWAIT) || (state == ST_DROP));

        if (restart) begin
            cap     = 1'b1;
            cap_idx = '0;
            hidx_n  = IDX_W'(1);
            nstate  = in_eop ? ST_IDLE : ST_HDR;
        end else begin
            unique case (state)
                ST_IDLE: begin
                end
                ST_HDR: begin
                    if (in_valid) begin
                        cap = 1'b1;
                        if (hidx == IDX_LAST) begin
                            if (!hdr_ok) begin
                                nstate = in_eop ? ST_IDLE : ST_DROP;
                            end else begin
                                load     = 1'b1;
                                stop_clr = 1'b1;
                                if (in_eop) begin
                                    nstate = ST_REQ;
                                end else begin
                                    nstate = is_wr ? ST_WDATA : ST_RWAIT;
                                end
                            end
                        end else begin
                            hidx_n = hidx + IDX_W'(1);
                            if (in_eop) begin
                                nstate = ST_IDLE;
                            end
                        end
                    end
                end
                ST_WDATA: begin
                    if (in_valid) begin
                        if (!empty && !stopped) begin
                            bus_wr = 1'b1;
                            if (bus_ack) begin
                                step = 1'b1;
                            end else begin
                                stop_set = 1'b1;
                            end
                        end
                        if (in_eop) begin
                            nstate = ST_REQ;
                        end
                    end
                end
                ST_RWAIT: begin
                    if (in_valid && in_eop) begin
                        nstate = ST_REQ;
                    end
                end
                ST_DROP: begin
                    if (in_valid && in_eop) begin
                        nstate = ST_IDLE;
                    end
                end
                ST_REQ: begin
                    rsp_req = 1'b1;
                    if (rsp_gnt) begin
                        hidx_n = '0;
                        nstate = ST_SHDR;
                    end
                end
                ST_SHDR: begin
                    rsp_req    = 1'b1;
                    emit_valid = 1'b1;
                    emit_data  = echo_byte;
                    emit_sop   = (hidx == '0);
                    if (hidx == IDX_LAST) begin
                        nstate = is_wr ? ST_TAIL : ST_RXFER;
                    end else begin
                        hidx_n = hidx + IDX_W'(1);
                    end
                end
                ST_RXFER: begin
                    rsp_req = 1'b1;
                    if (empty) begin
                        nstate = ST_TAIL;
                    end else begin
                        bus_rd = 1'b1;
                        if (bus_ack) begin
                            step       = 1'b1;
                            emit_valid = 1'b1;
                            emit_data  = bus_rdata;
                        end else begin
                            nstate = ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    rsp_req    = 1'b1;
                    emit_valid = 1'b1;
                    emit_data  = left;
                    emit_eop   = 1'b1;
                    nstate     = ST_IDLE;
                end
                default: begin
                    nstate = ST_IDLE;
                end
            endcase
        end
    end

    AST_BUS_NEEDS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> hdr_ok);                                 // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));                                           // R4
    AST_OUT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rsp_req));                                  // R11
    AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHDR && hidx == '0) |-> $past(rsp_gnt));           // R11
    AST_RD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ack) |=> !bus_rd);                              // R7
    AST_WR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ack) |=> !bus_wr);                              // R8
    AST_WR_IN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> !empty);                                             // R9

endmodule

// File: tb/sim_rae_top.sv
module sim_rae_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic       rsp_req, rsp_gnt;
    logic       out_valid, out_sop, out_eop;
    logic [7:0] out_data;
    logic [4:0] bus_sel;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic       bus_rd, bus_wr, bus_ack;

    always #(CLK_PERIOD/2) clk = ~clk;

    rae_top u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .rsp_req(rsp_req), .rsp_gnt(rsp_gnt),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // Peripheral model
    logic [7:0] mem [256];
    int         acc = 0;
    int         strobes = 0;
    int         lim = -1;
    int         lim_base = 0;
    logic [4:0] last_sel = 5'd0;
    bit         hold = 1'b0;

    assign rsp_gnt   = rsp_req && !hold;
    assign bus_rdata = mem[bus_addr];
    assign bus_ack   = (lim < 0) || ((acc - lim_base) < lim);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else begin
            if (bus_wr && bus_ack) mem[bus_addr] <= bus_wdata;
            if (bus_rd || bus_wr) begin
                strobes  <= strobes + 1;
                last_sel <= bus_sel;
                if (bus_ack) acc <= acc + 1;
            end
        end
    end

    // Response collector
    logic [7:0] rbuf [2048];
    int r_total = 0, eop_cnt = 0, sop_cnt = 0;
    always @(posedge clk) begin
        if (rst_n && out_valid) begin
            rbuf[r_total % 2048] <= out_data;
            r_total <= r_total + 1;
            if (out_sop) sop_cnt <= sop_cnt + 1;
            if (out_eop) eop_cnt <= eop_cnt + 1;
        end
    end

    int errors = 0, checks = 0;
    logic [7:0] pkt [300];
    int pkt_n;
    logic [7:0] exp_b [300];
    int exp_n;
    int r_base, e_base, s_base, st_base;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic mark();
        r_base = r_total; e_base = eop_cnt; s_base = sop_cnt; st_base = strobes;
    endtask

    task automatic send(input bit with_eop);
        for (int i = 0; i < pkt_n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pkt[i];
            in_sop = (i == 0); in_eop = with_eop && (i == pkt_n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'h00;
    endtask

    task automatic hdr(input logic [7:0] c, input logic [7:0] p,
                       input logic [7:0] a, input logic [7:0] n);
        pkt[0] = c; pkt[1] = p; pkt[2] = a; pkt[3] = n; pkt_n = 4;
        exp_b[0] = c; exp_b[1] = p; exp_b[2] = a; exp_b[3] = n; exp_n = 4;
    endtask

    task automatic expect_rsp(input string req);
        int t;
        bit same;
        int bad;
        t = 0;
        while (eop_cnt == e_base && t < 2000) begin
            @(negedge clk); t++;
        end
        check(eop_cnt == e_base + 1, req, "response end count", eop_cnt - e_base, 1);
        check(sop_cnt == s_base + 1, req, "response start count", sop_cnt - s_base, 1);
        check(r_total - r_base == exp_n, req, "response length", r_total - r_base, exp_n);
        same = 1'b1; bad = 0;
        for (int i = 0; i < exp_n; i++) begin
            if (same && rbuf[(r_base + i) % 2048] !== exp_b[i]) begin
                same = 1'b0; bad = i;
            end
        end
        check(same, req, $sformatf("response byte %0d", bad),
              rbuf[(r_base + bad) % 2048], exp_b[bad]);
    endtask

    task automatic expect_silence(input string req, input int cycles);
        repeat (cycles) @(negedge clk);
        check(r_total == r_base, req, "bytes from discarded packet", r_total - r_base, 0);
        check(strobes == st_base, req, "bus strobes", strobes - st_base, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!out_valid && !rsp_req && !bus_rd && !bus_wr, "R11", "outputs after reset",
              {out_valid, rsp_req, bus_rd, bus_wr}, 0);
    endtask

    task automatic t_zero();
        mark(); hdr(8'hF6, 8'hE0, 8'h00, 8'h00);
        exp_b[4] = 8'h00; exp_n = 5;
        send(1'b1); expect_rsp("R10 zero count");
        check(strobes == st_base, "R10", "strobes for zero count", strobes - st_base, 0);
    endtask

    task automatic t_max();
        mark(); hdr(8'hF6, 8'hE0, 8'h00, 8'hFF);
        for (int i = 0; i < 255; i++) exp_b[4 + i] = 8'(i) ^ 8'h5A;
        exp_b[259] = 8'h00; exp_n = 260;
        send(1'b1); expect_rsp("R10 max count");
    endtask

    task automatic t_read_inc();
        mark(); hdr(8'hF6, 8'hE3, 8'h10, 8'h04);
        for (int i = 0; i < 4; i++) exp_b[4 + i] = 8'(8'h10 + i) ^ 8'h5A;
        exp_b[8] = 8'h00; exp_n = 9;
        send(1'b1); expect_rsp("R2 incrementing read");
        check(last_sel == 5'd3, "R4", "bus_sel", last_sel, 3);
    endtask

    task automatic t_read_fix();
        mark(); hdr(8'hF4, 8'hFD, 8'h20, 8'h03);
        for (int i = 0; i < 3; i++) exp_b[4 + i] = 8'h20 ^ 8'h5A;
        exp_b[7] = 8'h00; exp_n = 8;
        send(1'b1); expect_rsp("R2 fixed read");
        check(last_sel == 5'd29, "R4", "bus_sel", last_sel, 29);
    endtask

    task automatic t_wrap();
        mark(); hdr(8'hF6, 8'hE0, 8'hFE, 8'h03);
        exp_b[4] = 8'hFE ^ 8'h5A; exp_b[5] = 8'hFF ^ 8'h5A; exp_b[6] = 8'h00 ^ 8'h5A;
        exp_b[7] = 8'h00; exp_n = 8;
        send(1'b1); expect_rsp("R6 address wrap");
    endtask

    task automatic t_read_short();
        lim_base = acc; lim = 2;
        mark(); hdr(8'hF6, 8'hE0, 8'h50, 8'h05);
        exp_b[4] = 8'h50 ^ 8'h5A; exp_b[5] = 8'h51 ^ 8'h5A;
        exp_b[6] = 8'h03; exp_n = 7;
        send(1'b1); expect_rsp("R7 read stopped by accept");
        lim = -1;
    endtask

    task automatic t_write_inc();
        mark(); hdr(8'hFA, 8'hE1, 8'h30, 8'h03);
        pkt[4] = 8'hA1; pkt[5] = 8'hB2; pkt[6] = 8'hC3; pkt_n = 7;
        exp_b[4] = 8'h00; exp_n = 5;
        send(1'b1); expect_rsp("R3 incrementing write");
        check(mem[8'h30] == 8'hA1 && mem[8'h31] == 8'hB2 && mem[8'h32] == 8'hC3,
              "R3", "incrementing write contents", {mem[8'h30], mem[8'h31], mem[8'h32]},
              24'hA1B2C3);
        check(last_sel == 5'd1, "R4", "bus_sel on write", last_sel, 1);
    endtask

    task automatic t_write_fix();
        mark(); hdr(8'hF8, 8'hE2, 8'h40, 8'h03);
        pkt[4] = 8'h11; pkt[5] = 8'h22; pkt[6] = 8'h33; pkt_n = 7;
        exp_b[4] = 8'h00; exp_n = 5;
        send(1'b1); expect_rsp("R3 fixed write");
        check(mem[8'h40] == 8'h33 && mem[8'h41] == (8'h41 ^ 8'h5A), "R3",
              "fixed write contents", {mem[8'h40], mem[8'h41]}, {8'h33, 8'h41 ^ 8'h5A});
    endtask

    task automatic t_write_drop();
        lim_base = acc; lim = 1;
        mark(); hdr(8'hFA, 8'hE0, 8'h60, 8'h03);
        pkt[4] = 8'h77; pkt[5] = 8'h88; pkt[6] = 8'h99; pkt_n = 7;
        exp_b[4] = 8'h02; exp_n = 5;
        send(1'b1);
        lim = -1;
        expect_rsp("R8 write stopped by accept");
        check(strobes - st_base == 2, "R8", "write strobes", strobes - st_base, 2);
        check(mem[8'h60] == 8'h77 && mem[8'h61] == (8'h61 ^ 8'h5A) &&
              mem[8'h62] == (8'h62 ^ 8'h5A), "R8", "dropped write contents",
              {mem[8'h60], mem[8'h61], mem[8'h62]}, {8'h77, 8'h61 ^ 8'h5A, 8'h62 ^ 8'h5A});
    endtask

    task automatic t_write_few();
        mark(); hdr(8'hFA, 8'hE0, 8'h70, 8'h04);
        pkt[4] = 8'h01; pkt[5] = 8'h02; pkt_n = 6;
        exp_b[4] = 8'h02; exp_n = 5;
        send(1'b1); expect_rsp("R9 short write packet");
        check(mem[8'h72] == (8'h72 ^ 8'h5A), "R9", "unwritten register",
              mem[8'h72], 8'h72 ^ 8'h5A);
    endtask

    task automatic t_write_surplus();
        mark(); hdr(8'hFA, 8'hE0, 8'h78, 8'h01);
        pkt[4] = 8'hC7; pkt[5] = 8'hD8; pkt_n = 6;
        exp_b[4] = 8'h00; exp_n = 5;
        send(1'b1); expect_rsp("R9 surplus write data");
        check(mem[8'h78] == 8'hC7 && mem[8'h79] == (8'h79 ^ 8'h5A), "R9",
              "surplus byte not written", {mem[8'h78], mem[8'h79]}, {8'hC7, 8'h79 ^ 8'h5A});
    endtask

    task automatic t_bad();
        mark(); hdr(8'h55, 8'hE0, 8'h00, 8'h01);
        send(1'b1); expect_silence("R5 unknown command", 30);
        mark(); hdr(8'hF4, 8'hC1, 8'h00, 8'h01);
        send(1'b1); expect_silence("R5 bad peripheral prefix", 30);
        mark(); hdr(8'hFA, 8'h61, 8'h00, 8'h01); pkt[4] = 8'hEE; pkt_n = 5;
        send(1'b1); expect_silence("R5 bad prefix write", 30);
        mark(); hdr(8'hF6, 8'hE0, 8'h00, 8'h01); pkt_n = 3;
        send(1'b1); expect_silence("R5 short header", 30);
    endtask

    task automatic t_grant();
        hold = 1'b1;
        mark(); hdr(8'hF6, 8'hE4, 8'h12, 8'h02);
        send(1'b1);
        repeat (10) @(negedge clk);
        check(rsp_req, "R11", "request while waiting", rsp_req, 1);
        check(r_total == r_base && strobes == st_base, "R11", "activity before grant",
              r_total - r_base + strobes - st_base, 0);
        hdr(8'hF4, 8'hE0, 8'h20, 8'h01);
        send(1'b1);
        hdr(8'hF6, 8'hE4, 8'h12, 8'h02);
        exp_b[4] = 8'h12 ^ 8'h5A; exp_b[5] = 8'h13 ^ 8'h5A; exp_b[6] = 8'h00; exp_n = 7;
        hold = 1'b0;
        expect_rsp("R11 granted response");
        check(!rsp_req, "R11", "request dropped after response", rsp_req, 0);
        mark();
        expect_silence("R12 packet during pending response", 40);
    endtask

    task automatic t_restart();
        mark(); hdr(8'hF4, 8'hE0, 8'h00, 8'h00); pkt_n = 2;
        send(1'b0);
        hdr(8'hF6, 8'hE1, 8'h10, 8'h02);
        exp_b[4] = 8'h10 ^ 8'h5A; exp_b[5] = 8'h11 ^ 8'h5A; exp_b[6] = 8'h00; exp_n = 7;
        send(1'b1); expect_rsp("R12 restart on start marker");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero();
        t_max();
        t_read_inc();
        t_read_fix();
        t_wrap();
        t_read_short();
        t_write_inc();
        t_write_fix();
        t_write_drop();
        t_write_few();
        t_write_surplus();
        t_bad();
        t_grant();
        t_restart();
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

endmodule